// File: doc/BRIEF.md
# Cascadable Phase Accumulator

This block is the phase core of a numerically controlled oscillator. It keeps a running phase of `PHASE_W` bits. On every clock edge it adds an increment word and a one-bit carry input to that phase, modulo 2^PHASE_W. The output frequency is therefore the clock frequency times the increment, divided by 2^PHASE_W. The upper `TOP_W` bits of the phase go out to the waveform stage. A registered wrap flag goes out beside them and pulses for one cycle whenever a sum runs past the largest representable phase.

Two instances can be chained to double the frequency resolution. The wrap flag of the low-order instance feeds the carry input of the high-order instance, and the low instance keeps its own carry input tied to zero. A synchronous clear restarts the phase from zero. An optional output register stage delays the exported phase and the wrap flag together by one cycle to ease timing. The adder is built from carry-chained segments of `SEG_W` bits.

Top module: `casc_phase_acc`

## Requirements
- R1: With `clr_i` low, each rising edge loads phase + `incr_i` + `carry_i`, modulo 2^PHASE_W. With `incr_i` = 0 and `carry_i` = 0 the phase holds.
- R2: `carry_i` = 1 adds exactly one to the increment for that cycle. With `incr_i` all ones and `carry_i` = 1, the phase does not move and the wrap flag is 1 on every cycle.
- R3: The wrap flag is 1 for the cycle after an edge whose unreduced sum exceeded 2^PHASE_W - 1, and 0 otherwise. It is registered on the same edge as the phase it belongs to.
- R4: `clr_i` high at an edge forces the phase and the wrap flag to 0, whatever the increment. Accumulation restarts from zero on the next edge.
- R5: While `rst_ni` is low (asynchronous), the phase, the wrap flag and any output stage are 0.
- R6: `phase_top_o` carries bits PHASE_W-1 down to PHASE_W-TOP_W of the phase, MSB first.
- R7: With `OUT_MODE` = OUT_STAGED, `phase_top_o` and `carry_o` show the core values one cycle later, aligned with each other. A clear also zeroes this stage on the same edge.
- R8: In a cascade cleared together, with the low increment Il, the high increment Ih and the combined accumulator A(t) = t*(Ih*2^PHASE_W + Il), the high instance phase at cycle t equals floor(A(t-1)/2^PHASE_W) + Ih (mod 2^PHASE_W): the low carry lands one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous phase clear |
| incr_i | input | PHASE_W | Phase increment word |
| carry_i | input | 1 | Extra +1 on the increment (cascade input) |
| phase_top_o | output | TOP_W | Most significant phase bits |
| carry_o | output | 1 | One-cycle wrap flag (cascade output) |

## Verification
The bench runs a small 8-bit configuration. It sweeps every increment value, mixing carry-in patterns, and compares each cycle against arithmetic models. The corner cases are these:
- An increment of all ones with carry-in set. A design that wraps the extra one wrongly would drift, or would drop the carry pulse.
- A clear arriving while a nonzero increment is active. A design that lets the adder win would restart from a nonzero phase.
- The staged output mode. A design that misaligns the stage would show the wrap flag one cycle off from its phase.
- The chained pair. A design that carries combinationally, or late by more than one cycle, would move the high-order phase at the wrong moment.

// File: rtl/casc_nco_pkg.sv
package casc_nco_pkg;
  localparam int unsigned DEF_PHASE_W = 32;
  localparam int unsigned DEF_SEG_W   = 8;
  localparam int unsigned DEF_TOP_W   = 12;

  typedef enum logic {
    OUT_DIRECT = 1'b0,
    OUT_STAGED = 1'b1
  } out_mode_e;
endpackage

// File: rtl/acc_seg.sv
module acc_seg #(
  parameter int unsigned SEG_W = 8
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             c_i,
  output logic [SEG_W-1:0] s_o,
  output logic             c_o
);
  logic [SEG_W:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i} + {{SEG_W{1'b0}}, c_i};
  assign s_o = sum[SEG_W-1:0];
  assign c_o = sum[SEG_W];
endmodule

// File: rtl/phase_core.sv
module phase_core #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned SEG_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] incr_i,
  input  logic               carry_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  localparam int unsigned NSEG = PHASE_W / SEG_W;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] sum_w;
  logic [NSEG:0]      cy;
  logic               wrap_q;

  assign cy[0] = carry_i;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    acc_seg #(.SEG_W(SEG_W)) u_seg (
      .a_i (phase_q[g*SEG_W +: SEG_W]),
      .b_i (incr_i[g*SEG_W +: SEG_W]),
      .c_i (cy[g]),
      .s_o (sum_w[g*SEG_W +: SEG_W]),
      .c_o (cy[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else if (clr_i) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= sum_w;
      wrap_q  <= cy[NSEG];
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

  a_r1_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> phase_q == PHASE_W'($past(phase_q) + $past(incr_i) + PHASE_W'($past(carry_i))));

  a_r3_wrap_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (!wrap_q || phase_q <= $past(phase_q)));

  a_r3_nowrap_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (wrap_q || phase_q >= $past(phase_q)));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0 && !wrap_q));
endmodule

// File: rtl/out_stage.sv
module out_stage
  import casc_nco_pkg::*;
#(
  parameter int unsigned TOP_W    = 12,
  parameter out_mode_e   OUT_MODE = OUT_DIRECT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [TOP_W-1:0] top_i,
  input  logic             wrap_i,
  output logic [TOP_W-1:0] top_o,
  output logic             wrap_o
);
  if (OUT_MODE == OUT_STAGED) begin : g_staged
    logic [TOP_W-1:0] top_q;
    logic             wrap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        top_q  <= '0;
        wrap_q <= 1'b0;
      end else if (clr_i) begin
        top_q  <= '0;
        wrap_q <= 1'b0;
      end else begin
        top_q  <= top_i;
        wrap_q <= wrap_i;
      end
    end

    assign top_o  = top_q;
    assign wrap_o = wrap_q;

    a_r7_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (top_o == $past(top_i) && wrap_o == $past(wrap_i)));

    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (top_o == '0 && !wrap_o));
  end else begin : g_direct
    assign top_o  = top_i;
    assign wrap_o = wrap_i;
  end
endmodule

// File: rtl/casc_phase_acc.sv
module casc_phase_acc
  import casc_nco_pkg::*;
#(
  parameter int unsigned PHASE_W  = DEF_PHASE_W,
  parameter int unsigned SEG_W    = DEF_SEG_W,
  parameter int unsigned TOP_W    = DEF_TOP_W,
  parameter out_mode_e   OUT_MODE = OUT_DIRECT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] incr_i,
  input  logic               carry_i,
  output logic [TOP_W-1:0]   phase_top_o,
  output logic               carry_o
);
  localparam int unsigned TOP_LSB = PHASE_W - TOP_W;

  logic [PHASE_W-1:0] phase;
  logic               wrap;

  phase_core #(.PHASE_W(PHASE_W), .SEG_W(SEG_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .incr_i  (incr_i),
    .carry_i (carry_i),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  out_stage #(.TOP_W(TOP_W), .OUT_MODE(OUT_MODE)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .top_i  (phase[PHASE_W-1:TOP_LSB]),
    .wrap_i (wrap),
    .top_o  (phase_top_o),
    .wrap_o (carry_o)
  );

  // R5: reset state seen at the pins
  a_r5_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_top_o == '0 && !carry_o));
endmodule

// File: tb/sim_casc_phase_acc.sv
module sim_casc_phase_acc;
  import casc_nco_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, clr, cin;
  logic [7:0] inc, inc_hi;
  logic [3:0] top0, top1, top_lo, top_hi;
  logic       cy0, cy1, cy_lo, cy_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  casc_phase_acc #(.PHASE_W(8), .SEG_W(4), .TOP_W(4), .OUT_MODE(OUT_DIRECT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .incr_i(inc), .carry_i(cin),
    .phase_top_o(top0), .carry_o(cy0));

  casc_phase_acc #(.PHASE_W(8), .SEG_W(4), .TOP_W(4), .OUT_MODE(OUT_STAGED)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .incr_i(inc), .carry_i(cin),
    .phase_top_o(top1), .carry_o(cy1));

  casc_phase_acc #(.PHASE_W(8), .SEG_W(4), .TOP_W(4), .OUT_MODE(OUT_DIRECT)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .incr_i(inc), .carry_i(1'b0),
    .phase_top_o(top_lo), .carry_o(cy_lo));

  casc_phase_acc #(.PHASE_W(8), .SEG_W(4), .TOP_W(4), .OUT_MODE(OUT_DIRECT)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .incr_i(inc_hi), .carry_i(cy_lo),
    .phase_top_o(top_hi), .carry_o(cy_hi));

  // models
  logic [7:0]  m_ph;
  logic        m_wr;
  logic [3:0]  m_oph;
  logic        m_owr;
  logic [15:0] m_a;
  logic [7:0]  m_up;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [7:0] i, input logic c, input logic cl, input logic [7:0] ih);
    logic [8:0]  s;
    logic [15:0] a_old;
    string       rq;
    inc = i; cin = c; clr = cl; inc_hi = ih;
    @(posedge clk);
    s     = {1'b0, m_ph} + {1'b0, i} + {8'd0, c};
    a_old = m_a;
    if (cl) begin
      m_oph = '0; m_owr = 1'b0; m_ph = '0; m_wr = 1'b0; m_a = '0; m_up = '0;
    end else begin
      m_oph = m_ph[7:4]; m_owr = m_wr;
      m_ph  = s[7:0];    m_wr  = s[8];
      m_a   = a_old + {ih, i};
      m_up  = a_old[15:8] + ih;
    end
    @(negedge clk);
    rq = cl ? "R4" : (c ? "R2" : "R1");
    chk({rq, "/R6 phase top"}, top0, m_ph[7:4]);
    chk(cl ? "R4 wrap" : "R3 wrap", cy0, m_wr);
    chk("R7 staged top", top1, m_oph);
    chk("R7 staged wrap", cy1, m_owr);
    chk("R8 low top", top_lo, m_a[7:4]);
    chk("R8 high top", top_hi, m_up[7:4]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; inc = 8'hFF; cin = 1'b1; inc_hi = 8'hFF;
    m_ph = '0; m_wr = 1'b0; m_oph = '0; m_owr = 1'b0; m_a = '0; m_up = '0;
    repeat (3) @(negedge clk);
    // R5: clocks run with reset low and nonzero increment
    chk("R5 reset top", top0, 0);
    chk("R5 reset wrap", cy0, 0);
    chk("R5 reset staged top", top1, 0);
    chk("R5 reset staged wrap", cy1, 0);
    chk("R5 reset cascade", top_hi, 0);
    rst_n = 1'b1;

    // R1/R2/R3: sweep every increment with mixed carry-in
    for (int v = 0; v < 256; v++) begin
      step(8'(v), 1'b0, 1'b1, 8'(v) ^ 8'h5A);
      for (int k = 0; k < 10; k++)
        step(8'(v), (k % 3) == 1, 1'b0, 8'(v) ^ 8'h5A);
    end

    // R2: all-ones increment plus carry-in keeps the phase, wraps every cycle
    step(8'h30, 1'b0, 1'b1, 8'h01);
    step(8'h30, 1'b0, 1'b0, 8'h01);
    for (int k = 0; k < 6; k++) step(8'hFF, 1'b1, 1'b0, 8'h01);

    // R4: clear beats a live large increment mid-run
    for (int k = 0; k < 5; k++) step(8'hC7, 1'b1, 1'b0, 8'h03);
    step(8'hC7, 1'b1, 1'b1, 8'h03);
    for (int k = 0; k < 4; k++) step(8'hC7, 1'b0, 1'b0, 8'h03);

    // R1: zero increment holds phase
    step(8'h50, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) step(8'h00, 1'b0, 1'b0, 8'h00);

    // R8: long cascade run with fine low increment
    step(8'h00, 1'b0, 1'b1, 8'h00);
    for (int k = 0; k < 600; k++) step(8'h0B, 1'b0, 1'b0, 8'h02);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule